// File: doc/BRIEF.md
# Bus Stall Watchdog Timer

This block guards a two-wire serial bus master against a bus that stops moving, for example a target that holds the clock line low indefinitely. While the master engine reports that it is waiting on the bus, a 15-bit down-counter decrements once per prescaled tick. The tick period is a power of two of the input clock, selected by a log2 code. When the count runs out, the block emits a single one-cycle timeout pulse toward the master engine. The engine records that pulse as its timeout status flag.

Any clock-line edge seen by the master counts as bus progress. Progress reloads the counter from the programmed value and restarts the prescaler, so only a stall longer than the programmed window produces a pulse. The control word holds an enable flag and the window value. Clearing the enable stops the timer, and setting it again starts a fresh window. After an expiry the timer stays quiet until the bus makes progress or the control word is rewritten with the enable set.

All pins are plain control and status signals. There is no data stream, so no valid/ready handshake is involved.

Top module: `bus_wait_timer`

## Requirements
- R1: After reset the timeout output is low, the timer is disabled and the prescale code is 0. While disabled, a held wait input never produces a pulse.
- R2: A control write (`ctl_we`) stores the enable in bit 15 and the window value V in bits 14:0. A write with bit 15 set loads the counter with V and restarts the prescaler.
- R3: The prescale code p (`pre_we`, 4 bits) makes one tick every 2^p counted cycles. Codes above 14 act as 14.
- R4: With the wait input held high after a load, the pulse is high in the cycle after the (V·2^p)-th counted clock edge. A value of 0 acts as 1.
- R5: Counting and prescaling happen only on edges where `bus_wait` is high. Cycles with it low hold both, and each such cycle delays the expiry by one cycle.
- R6: A `scl_edge` strobe while enabled, and without a control write in the same cycle, reloads the counter from the stored value and re-arms the timer.
- R7: Each expiry gives exactly one pulse, one cycle wide. No further pulse occurs, however long the wait continues, until a reload.
- R8: While disabled the timer neither counts nor pulses, and `scl_edge` is ignored. The next enabling write starts a complete new window.
- R9: A load on the same edge as a pending expiry wins: no pulse is emitted, and a full new window starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word: bit 15 enable, bits 14:0 window value |
| pre_we | input | 1 | Prescale code write strobe |
| pre_wdata | input | 4 | Prescale code (log2 of tick period) |
| bus_wait | input | 1 | Master is waiting on the bus |
| scl_edge | input | 1 | Clock-line edge seen (bus progress) |
| timeout_o | output | 1 | One-cycle expiry pulse |

## Verification
The bench builds the block with its default parameters: a 15-bit counter and a largest prescale code of 14. At these values the out-of-range prescale code 15 clamps to a 16384-cycle tick, and a one-tick window at that setting ends within the run's budget. Every expiry time is predicted from V·2^p plus any idle cycles. This covers reloads that land exactly on an expiry edge, pauses in the middle of a window, and progress strobes while the timer is disabled.

// File: rtl/bwt_pkg.sv
package bwt_pkg;
  localparam int unsigned BWT_CNT_W   = 15;
  localparam int unsigned BWT_PRE_MAX = 14;

  typedef enum logic [1:0] {
    LD_NONE  = 2'd0,
    LD_WRITE = 2'd1,
    LD_PROG  = 2'd2
  } load_src_e;
endpackage

// File: rtl/bwt_cfg_regs.sv
module bwt_cfg_regs
  import bwt_pkg::*;
#(
  parameter int CNT_W   = 15,
  parameter int PRE_MAX = 14,
  parameter int PRE_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CNT_W:0]   ctl_wdata,
  input  logic             pre_we,
  input  logic [PRE_W-1:0] pre_wdata,
  input  logic             scl_edge,
  output logic             en,
  output logic [CNT_W-1:0] val,
  output logic [PRE_W-1:0] pre_sel,
  output logic             load,
  output logic [CNT_W-1:0] load_val
);
  localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(PRE_MAX);

  load_src_e src;

  always_comb begin
    src = LD_NONE;
    if (ctl_we) begin
      if (ctl_wdata[CNT_W]) src = LD_WRITE;
    end else if (scl_edge && en) begin
      src = LD_PROG;
    end
  end

  assign load     = (src != LD_NONE);
  assign load_val = (src == LD_WRITE) ? ctl_wdata[CNT_W-1:0] : val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= 1'b0;
      val     <= '0;
      pre_sel <= '0;
    end else begin
      if (ctl_we) begin
        en  <= ctl_wdata[CNT_W];
        val <= ctl_wdata[CNT_W-1:0];
      end
      if (pre_we) pre_sel <= (pre_wdata > PRE_TOP) ? PRE_TOP : pre_wdata;
    end
  end
endmodule

// File: rtl/bwt_prescaler.sv
module bwt_prescaler #(
  parameter int PRE_MAX = 14,
  parameter int PRE_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [PRE_W-1:0] pre_sel,
  output logic             tick
);
  logic [PRE_MAX-1:0] pcnt;
  logic [PRE_MAX-1:0] mask;

  // Low pre_sel bits of the phase counter must all be ones for a tick.
  assign mask = ~({PRE_MAX{1'b1}} << pre_sel);
  assign tick = step && ((pcnt & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pcnt <= '0;
    else if (clear) pcnt <= '0;
    else if (step)  pcnt <= pcnt + 1'b1;
  end
endmodule

// File: rtl/bwt_downcounter.sv
module bwt_downcounter #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             en,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             armed,
  output logic             expire
);
  logic last_tick;
  assign last_tick = (count <= CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      armed  <= 1'b0;
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (load) begin
        count <= load_val;
        armed <= 1'b1;
      end else if (en && armed && tick) begin
        if (last_tick) begin
          armed  <= 1'b0;
          expire <= 1'b1;
        end else begin
          count <= count - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bus_wait_timer.sv
module bus_wait_timer #(
  parameter int CNT_W   = bwt_pkg::BWT_CNT_W,
  parameter int PRE_MAX = bwt_pkg::BWT_PRE_MAX,
  localparam int PRE_W  = $clog2(PRE_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CNT_W:0]   ctl_wdata,
  input  logic             pre_we,
  input  logic [PRE_W-1:0] pre_wdata,
  input  logic             bus_wait,
  input  logic             scl_edge,
  output logic             timeout_o
);
  logic             tmr_en;
  logic [CNT_W-1:0] tmr_val;
  logic [PRE_W-1:0] tmr_pre;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_load_val;
  logic             tmr_tick;
  logic             tmr_step;
  logic [CNT_W-1:0] tmr_count;
  logic             tmr_armed;

  bwt_cfg_regs #(.CNT_W(CNT_W), .PRE_MAX(PRE_MAX), .PRE_W(PRE_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_we   (ctl_we),
    .ctl_wdata(ctl_wdata),
    .pre_we   (pre_we),
    .pre_wdata(pre_wdata),
    .scl_edge (scl_edge),
    .en       (tmr_en),
    .val      (tmr_val),
    .pre_sel  (tmr_pre),
    .load     (tmr_load),
    .load_val (tmr_load_val)
  );

  assign tmr_step = tmr_en && tmr_armed && bus_wait && !tmr_load;

  bwt_prescaler #(.PRE_MAX(PRE_MAX), .PRE_W(PRE_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (tmr_load),
    .step   (tmr_step),
    .pre_sel(tmr_pre),
    .tick   (tmr_tick)
  );

  bwt_downcounter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_load_val),
    .en      (tmr_en),
    .tick    (tmr_tick),
    .count   (tmr_count),
    .armed   (tmr_armed),
    .expire  (timeout_o)
  );
endmodule

// File: rtl/bwt_checker.sv
module bwt_checker #(
  parameter int CNT_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_we,
  input logic [CNT_W:0]   ctl_wdata,
  input logic             scl_edge,
  input logic             bus_wait,
  input logic             timeout_o,
  input logic             en,
  input logic             armed,
  input logic             load,
  input logic [CNT_W-1:0] val,
  input logic [CNT_W-1:0] count
);
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !timeout_o);

  a_r7_disarm_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> !armed);

  a_r8_no_pulse_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !timeout_o);

  a_r2_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_wdata[CNT_W]) |=> (en && armed && count == $past(ctl_wdata[CNT_W-1:0])));

  a_r6_progress_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_edge && en && !ctl_we) |=> (armed && count == $past(val)));

  a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wait && !load) |=> ($stable(count) && !timeout_o));

  a_r4_count_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (count <= $past(count)));

  a_r9_load_beats_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !timeout_o);
endmodule

bind bus_wait_timer bwt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ctl_we   (ctl_we),
  .ctl_wdata(ctl_wdata),
  .scl_edge (scl_edge),
  .bus_wait (bus_wait),
  .timeout_o(timeout_o),
  .en       (tmr_en),
  .armed    (tmr_armed),
  .load     (tmr_load),
  .val      (tmr_val),
  .count    (tmr_count)
);

// File: tb/bus_wait_timer_tb.sv
module bus_wait_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [15:0] ctl_wdata = '0;
  logic        pre_we = 1'b0;
  logic [3:0]  pre_wdata = '0;
  logic        bus_wait = 1'b0;
  logic        scl_edge = 1'b0;
  logic        timeout_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int pulse_count = 0;
  int exp_q[$];

  always #5 clk = ~clk;

  bus_wait_timer u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .pre_we(pre_we), .pre_wdata(pre_wdata), .bus_wait(bus_wait),
    .scl_edge(scl_edge), .timeout_o(timeout_o)
  );

  // Monitor: pops the expected expiry cycle on every pulse.
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n && timeout_o) begin
        pulse_count++;
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R7/R9: unexpected pulse at cycle %0d (actual 1, expected 0)", cyc);
        end else begin
          int e;
          e = exp_q.pop_front();
          if (cyc != e) begin
            errors++;
            $display("FAIL R4: pulse cycle actual %0d expected %0d", cyc, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R4: watchdog expired (actual hang, expected finish)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step_n(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr_ctl(input bit en, input int v, output int t0);
    @(posedge clk); #1;
    ctl_we = 1'b1; ctl_wdata = {en, 15'(v)}; t0 = cyc;
    @(posedge clk); #1;
    ctl_we = 1'b0;
  endtask

  task automatic wr_pre(input int p);
    @(posedge clk); #1;
    pre_we = 1'b1; pre_wdata = 4'(p);
    @(posedge clk); #1;
    pre_we = 1'b0;
  endtask

  task automatic pulse_scl(output int t0);
    @(posedge clk); #1;
    scl_edge = 1'b1; t0 = cyc;
    @(posedge clk); #1;
    scl_edge = 1'b0;
  endtask

  task automatic wait_q(input string req);
    int g = 0;
    while (exp_q.size() != 0 && g < 40000) begin @(posedge clk); #1; g++; end
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    exp_q.delete();
    step_n(2);
  endtask

  initial begin
    int t;
    int pc;
    step_n(3);
    rst_n = 1'b1;
    step_n(1);
    // R1: idle after reset, disabled so a held wait gives nothing
    chk(timeout_o == 1'b0, "R1 reset output", timeout_o, 0);
    bus_wait = 1'b1;
    step_n(40);
    chk(pulse_count == 0, "R1 disabled after reset", pulse_count, 0);

    // R2/R4: prescale still 0 from reset, V=5
    wr_ctl(1, 5, t); exp_q.push_back(t + 5 + 2);
    wait_q("R2 enable load");

    // R7: no second pulse while the wait continues
    pc = pulse_count;
    step_n(100);
    chk(pulse_count == pc, "R7 stays expired", pulse_count, pc);

    // R6: progress strobe re-arms from stored value
    pulse_scl(t); exp_q.push_back(t + 5 + 2);
    wait_q("R6 rearm");

    // R6: progress mid-window restarts the window
    wr_ctl(1, 20, t);
    step_n(10);
    pulse_scl(t); exp_q.push_back(t + 20 + 2);
    wait_q("R6 reload mid window");

    // R4: value 0 acts as 1
    wr_ctl(1, 0, t); exp_q.push_back(t + 1 + 2);
    wait_q("R4 zero value");

    // R3: p=3, V=4 -> 32 cycles
    wr_pre(3);
    wr_ctl(1, 4, t); exp_q.push_back(t + 32 + 2);
    wait_q("R3 prescale 3");

    // R5: p=2, V=3 -> 12 counted, 6 idle cycles inserted
    wr_pre(2);
    wr_ctl(1, 3, t); exp_q.push_back(t + 12 + 2 + 6);
    step_n(4);
    bus_wait = 1'b0;
    step_n(6);
    bus_wait = 1'b1;
    wait_q("R5 pause");

    // R9: reload coincides with the expiry edge, p=0 V=3
    wr_pre(0);
    wr_ctl(1, 3, t);
    step_n(1);
    wr_ctl(1, 3, t); exp_q.push_back(t + 3 + 2);
    wait_q("R9 load wins");

    // R8: disable mid window, strobe progress while off, then re-enable
    wr_ctl(1, 8, t);
    step_n(3);
    wr_ctl(0, 8, t);
    pc = pulse_count;
    step_n(30);
    pulse_scl(t);
    step_n(30);
    chk(pulse_count == pc, "R8 disabled silent", pulse_count, pc);
    wr_ctl(1, 8, t); exp_q.push_back(t + 8 + 2);
    wait_q("R8 re-enable full window");

    // R3: code 15 clamps to 14 -> 16384 cycles for V=1
    wr_pre(15);
    wr_ctl(1, 1, t); exp_q.push_back(t + 16384 + 2);
    wait_q("R3 clamp");

    step_n(5);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule